// File: doc/BRIEF.md
# Snooping Write-Back Cache Coherence Controller

This block keeps one private write-back cache coherent with its peers on a shared snooping bus. It holds a small direct-mapped array of lines. Each line has a tag, a single data word and a two-bit coherence state: Modified, Exclusive, Shared or Invalid. Processor reads and writes hit locally when the state allows it. Otherwise the controller takes a bus transaction: a line read, a read-for-ownership, an invalidate, or a writeback of a dirty victim. The arbiter answers each request with a single-cycle grant, and the whole transaction completes in that granted cycle.

The same controller also answers every transaction that another cache is granted. It reports that it holds a copy. When its own copy is dirty it returns the data and tells memory to discard its own answer; memory stores the data it returns. It then downgrades or invalidates its line. When two writers race for the same line, the bus order decides who goes first. The loser finds its copy invalidated, fetches the winner's data and only then writes.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request is raised while the processor is idle, and the first processor read of any address issues a line read (bus_cmd 0).
- R2: A read miss fills the line as Exclusive when bus_shared_in is low in the granted cycle and as Shared when it is high; a later write to a Shared fill issues an invalidate (bus_cmd 2), a write to an Exclusive fill issues nothing.
- R3: A read hit returns the stored word with cpu_ready high in the same cycle and raises no bus request.
- R4: A processor write to a line held Exclusive or Modified completes locally, with no bus transaction, and marks the line Modified.
- R5: A processor write to a line held Shared first issues an invalidate (bus_cmd 2) for the line address, then completes.
- R6: A processor write miss issues a read-for-ownership (bus_cmd 1) and completes once the line is filled.
- R7: A snooped line read (snoop_cmd 0) that hits a Modified line asserts snoop_supply and snoop_shared and drives the line word on snoop_data; memory stores that word, and the line becomes Shared.
- R8: A snooped line read that hits an Exclusive line asserts snoop_shared without snoop_supply, and the line becomes Shared.
- R9: A snooped read-for-ownership (snoop_cmd 1) or invalidate (snoop_cmd 2) that hits makes the line Invalid; a Modified line supplies its data first.
- R10: A miss whose victim line is Modified first writes the victim back (bus_cmd 3, victim address and data) and only then requests the new line.
- R11: In any cycle with snoop_valid high, cpu_ready is low: the snoop is serviced and the processor request waits.
- R12: When an invalidate from another cache wins the bus while this controller waits to upgrade the same line, the controller refetches it by read-for-ownership and writes on top of the winner's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Request completes at the next edge |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Writeback data |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DW | Fill data from the owner or memory |
| bus_shared_in | input | 1 | Another cache holds the requested line |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snoop_addr | input | AW | Snooped address |
| snoop_shared | output | 1 | This cache holds the snooped line |
| snoop_supply | output | 1 | This cache supplies data; memory answer cancelled |
| snoop_data | output | DW | Supplied line word |

## Verification
The bench builds two controllers with the defaults AW=8, IDX_W=2 and DW=16, and connects them through a shared memory model. With only four lines, a conflict miss needs just two addresses that differ above bit 1, so the dirty-victim writeback path is reached easily. A shared data word of 16 bits is enough to tell memory, owner and racing-writer values apart. A switchable arbiter priority lets the second cache win a same-cycle upgrade race, which exercises the refetch path.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} line_state_t;
  typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_INV = 2'd2, BC_WB = 2'd3} bus_cmd_t;
  typedef enum logic [1:0] {FS_IDLE, FS_WB, FS_FILL, FS_UPG} req_fsm_t;

  // line may be written without asking the bus
  function automatic logic owns_line(line_state_t s);
    return (s == LS_M) || (s == LS_E);
  endfunction

  // state a line takes after another cache's transaction hit it
  function automatic line_state_t after_snoop(line_state_t s, bus_cmd_t c);
    case (c)
      BC_RD:          return owns_line(s) ? LS_S : s;
      BC_RDX, BC_INV: return LS_I;
      default:        return s;
    endcase
  endfunction

  // state of a freshly filled line
  function automatic line_state_t after_fill(logic for_write, logic others_hold);
    return (for_write || !others_hold) ? LS_E : LS_S;
  endfunction
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output line_state_t      ra_state,
  output logic [TAG_W-1:0] ra_tag,
  output logic [DW-1:0]    ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output line_state_t      rb_state,
  output logic [TAG_W-1:0] rb_tag,
  output logic [DW-1:0]    rb_data,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  logic             wa_tag_en,
  input  logic [TAG_W-1:0] wa_tag,
  input  line_state_t      wa_state,
  input  logic             wa_data_en,
  input  logic [DW-1:0]    wa_data,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  line_state_t      wb_state
);
  localparam int LINES = 1 << IDX_W;

  line_state_t      st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [DW-1:0]    dat_q [LINES];

  // snoop port written last so it wins if both ever hit one line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_I;
    end else begin
      if (wa_en) st_q[wa_idx] <= wa_state;
      if (wb_en) st_q[wb_idx] <= wb_state;
    end
  end

  always_ff @(posedge clk) begin
    if (wa_en && wa_tag_en)  tag_q[wa_idx] <= wa_tag;
    if (wa_en && wa_data_en) dat_q[wa_idx] <= wa_data;
  end

  assign ra_state = st_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign ra_data  = dat_q[ra_idx];
  assign rb_state = st_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_data  = dat_q[rb_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  parameter int DW    = 16
) (
  input  logic                snoop_valid,
  input  bus_cmd_t            snoop_cmd,
  input  logic [AW-1:0]       snoop_addr,
  input  line_state_t         line_state,
  input  logic [AW-IDX_W-1:0] line_tag,
  input  logic [DW-1:0]       line_data,
  output logic                snoop_hit,
  output logic                snoop_shared,
  output logic                snoop_supply,
  output logic [DW-1:0]       snoop_data,
  output logic                upd_en,
  output line_state_t         upd_state
);
  assign snoop_hit    = snoop_valid && (line_state != LS_I) &&
                        (line_tag == snoop_addr[AW-1:IDX_W]);
  assign snoop_shared = snoop_hit && (snoop_cmd == BC_RD);
  assign snoop_supply = snoop_hit && (line_state == LS_M) &&
                        ((snoop_cmd == BC_RD) || (snoop_cmd == BC_RDX));
  assign snoop_data   = snoop_supply ? line_data : '0;
  assign upd_en       = snoop_hit && (snoop_cmd != BC_WB);
  assign upd_state    = after_snoop(line_state, snoop_cmd);
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [DW-1:0]       cpu_wdata,
  output logic                cpu_ready,
  output logic [DW-1:0]       cpu_rdata,
  input  logic                snoop_valid,
  output logic                bus_req,
  output bus_cmd_t            bus_cmd,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_wdata,
  input  logic                bus_gnt,
  input  logic [DW-1:0]       bus_rdata,
  input  logic                bus_shared_in,
  input  line_state_t         line_state,
  input  logic [AW-IDX_W-1:0] line_tag,
  input  logic [DW-1:0]       line_data,
  output logic                wa_en,
  output logic                wa_tag_en,
  output line_state_t         wa_state,
  output logic                wa_data_en,
  output logic [DW-1:0]       wa_data,
  output req_fsm_t            fsm_state
);
  req_fsm_t st_q, st_d;
  logic     hit;

  assign hit       = (line_state != LS_I) && (line_tag == cpu_addr[AW-1:IDX_W]);
  assign cpu_rdata = line_data;
  assign fsm_state = st_q;

  always_comb begin
    st_d       = st_q;
    cpu_ready  = 1'b0;
    bus_req    = 1'b0;
    bus_cmd    = BC_RD;
    bus_addr   = cpu_addr;
    bus_wdata  = line_data;
    wa_en      = 1'b0;
    wa_tag_en  = 1'b0;
    wa_state   = line_state;
    wa_data_en = 1'b0;
    wa_data    = cpu_wdata;
    case (st_q)
      FS_IDLE: begin
        if (cpu_req && !snoop_valid) begin
          if (hit && !cpu_we) begin
            cpu_ready = 1'b1;
          end else if (hit && owns_line(line_state)) begin
            cpu_ready  = 1'b1;
            wa_en      = 1'b1;
            wa_state   = LS_M;
            wa_data_en = 1'b1;
          end else if (hit) begin
            st_d = FS_UPG;
          end else if (line_state == LS_M) begin
            st_d = FS_WB;
          end else begin
            st_d = FS_FILL;
          end
        end
      end
      FS_WB: begin
        bus_req  = 1'b1;
        bus_cmd  = BC_WB;
        bus_addr = {line_tag, cpu_addr[IDX_W-1:0]};
        if (snoop_valid) begin
          st_d = FS_IDLE;
        end else if (bus_gnt) begin
          wa_en    = 1'b1;
          wa_state = LS_I;
          st_d     = FS_FILL;
        end
      end
      FS_FILL: begin
        bus_req = 1'b1;
        bus_cmd = cpu_we ? BC_RDX : BC_RD;
        if (snoop_valid) begin
          st_d = FS_IDLE;
        end else if (bus_gnt) begin
          wa_en      = 1'b1;
          wa_tag_en  = 1'b1;
          wa_data_en = 1'b1;
          wa_data    = bus_rdata;
          wa_state   = after_fill(cpu_we, bus_shared_in);
          st_d       = FS_IDLE;
        end
      end
      FS_UPG: begin
        bus_req = 1'b1;
        bus_cmd = BC_INV;
        if (snoop_valid) begin
          st_d = FS_IDLE;
        end else if (bus_gnt) begin
          wa_en    = 1'b1;
          wa_state = LS_M;
          st_d     = FS_IDLE;
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared_in,
  input  logic          snoop_valid,
  input  logic [1:0]    snoop_cmd,
  input  logic [AW-1:0] snoop_addr,
  output logic          snoop_shared,
  output logic          snoop_supply,
  output logic [DW-1:0] snoop_data
);
  localparam int TAG_W = AW - IDX_W;

  // named internal events for the checker
  line_state_t      cur_state, snp_state, wa_state, upd_state;
  logic [TAG_W-1:0] cur_tag, snp_tag;
  logic [DW-1:0]    cur_data, snp_data, wa_data;
  logic             wa_en, wa_tag_en, wa_data_en, upd_en, snoop_hit;
  bus_cmd_t         snp_cmd, req_cmd;
  req_fsm_t         fsm_state;

  assign snp_cmd = bus_cmd_t'(snoop_cmd);
  assign bus_cmd = req_cmd;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(cpu_addr[IDX_W-1:0]), .ra_state(cur_state), .ra_tag(cur_tag), .ra_data(cur_data),
    .rb_idx(snoop_addr[IDX_W-1:0]), .rb_state(snp_state), .rb_tag(snp_tag), .rb_data(snp_data),
    .wa_en(wa_en), .wa_idx(cpu_addr[IDX_W-1:0]), .wa_tag_en(wa_tag_en),
    .wa_tag(cpu_addr[AW-1:IDX_W]), .wa_state(wa_state),
    .wa_data_en(wa_data_en), .wa_data(wa_data),
    .wb_en(upd_en), .wb_idx(snoop_addr[IDX_W-1:0]), .wb_state(upd_state)
  );

  mesi_snoop_resp #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) u_snoop (
    .snoop_valid(snoop_valid), .snoop_cmd(snp_cmd), .snoop_addr(snoop_addr),
    .line_state(snp_state), .line_tag(snp_tag), .line_data(snp_data),
    .snoop_hit(snoop_hit), .snoop_shared(snoop_shared), .snoop_supply(snoop_supply),
    .snoop_data(snoop_data), .upd_en(upd_en), .upd_state(upd_state)
  );

  mesi_req_fsm #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .snoop_valid(snoop_valid),
    .bus_req(bus_req), .bus_cmd(req_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .line_state(cur_state), .line_tag(cur_tag), .line_data(cur_data),
    .wa_en(wa_en), .wa_tag_en(wa_tag_en), .wa_state(wa_state),
    .wa_data_en(wa_data_en), .wa_data(wa_data), .fsm_state(fsm_state)
  );
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk
  import mesi_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_ready,
  input logic [AW-1:0] cpu_addr,
  input logic          snoop_valid,
  input logic [1:0]    snoop_cmd,
  input logic          snoop_hit,
  input logic          snoop_supply,
  input line_state_t   snp_state,
  input line_state_t   cur_state,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [1:0]    bus_cmd,
  input logic          bus_shared_in
);
  assert_snoop_stalls_cpu_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |-> !cpu_ready);

  assert_supply_from_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_supply |-> (snoop_hit && snp_state == LS_M && snoop_cmd != 2'd2 && snoop_cmd != 2'd3));

  assert_local_write_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_ready) |-> (cur_state == LS_M || cur_state == LS_E));

  assert_upgrade_makes_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'd2) |=> (!$stable(cpu_addr) || cur_state == LS_M));

  assert_shared_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'd0 && bus_shared_in) |=>
      (!$stable(cpu_addr) || cur_state == LS_S));

  assert_bus_only_when_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_ready);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .cpu_addr(cpu_addr), .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd),
  .snoop_hit(snoop_hit), .snoop_supply(snoop_supply), .snp_state(snp_state),
  .cur_state(cur_state), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
  .bus_shared_in(bus_shared_in)
);

// File: tb/mesi_snoop_ctrl_bench.sv
module mesi_snoop_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LW = 2 + AW + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req [2], we [2], rdy [2], breq [2], gnt [2], bsh [2];
  logic          svalid [2], ssh [2], ssup [2];
  logic [AW-1:0] addr [2], baddr [2], saddr [2];
  logic [DW-1:0] wdata [2], rdata [2], bwdata [2], brdata [2], sdata [2];
  logic [1:0]    bcmd [2], scmd [2];
  logic          prefer_b = 1'b0;

  logic [DW-1:0] mem  [256];
  logic [DW-1:0] gold [256];
  logic [DW-1:0] expq0 [$], expq1 [$];
  logic [LW-1:0] log0 [$], log1 [$];
  int checks = 0, errors = 0, stall_seen = 0, cycles = 0;
  int sup_cnt [2];
  bit done = 1'b0;

  for (genvar g = 0; g < 2; g++) begin : g_cache
    if (g == 0) begin : g_main
      mesi_snoop_ctrl #(.AW(AW), .IDX_W(2), .DW(DW)) u_mesi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]),
        .cpu_wdata(wdata[0]), .cpu_ready(rdy[0]), .cpu_rdata(rdata[0]),
        .bus_req(breq[0]), .bus_cmd(bcmd[0]), .bus_addr(baddr[0]), .bus_wdata(bwdata[0]),
        .bus_gnt(gnt[0]), .bus_rdata(brdata[0]), .bus_shared_in(bsh[0]),
        .snoop_valid(svalid[0]), .snoop_cmd(scmd[0]), .snoop_addr(saddr[0]),
        .snoop_shared(ssh[0]), .snoop_supply(ssup[0]), .snoop_data(sdata[0]));
    end else begin : g_peer
      mesi_snoop_ctrl #(.AW(AW), .IDX_W(2), .DW(DW)) u_mesi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]),
        .cpu_wdata(wdata[1]), .cpu_ready(rdy[1]), .cpu_rdata(rdata[1]),
        .bus_req(breq[1]), .bus_cmd(bcmd[1]), .bus_addr(baddr[1]), .bus_wdata(bwdata[1]),
        .bus_gnt(gnt[1]), .bus_rdata(brdata[1]), .bus_shared_in(bsh[1]),
        .snoop_valid(svalid[1]), .snoop_cmd(scmd[1]), .snoop_addr(saddr[1]),
        .snoop_shared(ssh[1]), .snoop_supply(ssup[1]), .snoop_data(sdata[1]));
    end
  end

  // shared bus: one grant per cycle, other cache snoops it
  always_comb begin
    gnt[0]    = breq[0] && !(prefer_b && breq[1]);
    gnt[1]    = breq[1] && !gnt[0];
    svalid[1] = gnt[0];  scmd[1] = bcmd[0];  saddr[1] = baddr[0];
    svalid[0] = gnt[1];  scmd[0] = bcmd[1];  saddr[0] = baddr[1];
    brdata[0] = ssup[1] ? sdata[1] : mem[baddr[0]];
    brdata[1] = ssup[0] ? sdata[0] : mem[baddr[1]];
    bsh[0]    = ssh[1];
    bsh[1]    = ssh[0];
  end

  // memory: takes writebacks and data supplied by a dirty owner
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (gnt[i]) begin
        if (bcmd[i] == 2'd3)  mem[baddr[i]] <= bwdata[i];
        else if (ssup[1-i])   mem[baddr[i]] <= sdata[1-i];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pops, bus log, stall rule
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 2; i++) begin
        if (gnt[i]) begin
          if (i == 0) log0.push_back({bcmd[0], baddr[0], bwdata[0]});
          else        log1.push_back({bcmd[1], baddr[1], bwdata[1]});
        end
        if (ssup[i]) sup_cnt[i]++;
        if (req[i] && svalid[i]) begin
          stall_seen++;
          chk(!rdy[i], "R11 ready during snoop", 32'(rdy[i]), 32'd0);
        end
        if (req[i] && rdy[i] && !we[i]) begin
          logic [DW-1:0] e;
          if ((i == 0 ? expq0.size() : expq1.size()) == 0) begin
            chk(1'b0, "R3 unexpected read completion", 32'(rdata[i]), 32'd0);
          end else begin
            e = (i == 0) ? expq0.pop_front() : expq1.pop_front();
            chk(rdata[i] == e, "R3 read data", 32'(rdata[i]), 32'(e));
          end
        end
      end
    end
  end

  // driver: issues one processor request and records the expectation
  task automatic op(input int p, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr[p] = a; we[p] = w; wdata[p] = d; req[p] = 1'b1;
    if (!w) begin
      if (p == 0) expq0.push_back(gold[a]);
      else        expq1.push_back(gold[a]);
    end else begin
      gold[a] = d;
    end
    @(negedge clk);
    while (!rdy[p]) @(negedge clk);
    @(posedge clk);
    #2 req[p] = 1'b0;
  endtask

  task automatic clear_logs();
    log0.delete();
    log1.delete();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    int s0;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 16'h1000 + 16'(i);
      gold[i] = 16'h1000 + 16'(i);
    end
    for (int i = 0; i < 2; i++) begin
      req[i] = 1'b0; we[i] = 1'b0; addr[i] = '0; wdata[i] = '0; sup_cnt[i] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(breq[0] == 1'b0 && breq[1] == 1'b0, "R1 idle bus after reset", 32'(breq[0]), 32'd0);
    chk(rdy[0] == 1'b0, "R1 no ready while idle", 32'(rdy[0]), 32'd0);

    // R1: first read misses and issues a line read
    @(posedge clk); #2;
    clear_logs();
    op(0, 0, 8'h10, '0);
    chk(log0.size() == 1 && log0[0][LW-1 -: 2] == 2'd0, "R1 first read issues cmd 0",
        32'(log0.size()), 32'd1);

    // R3: read hit, no bus
    clear_logs();
    op(0, 0, 8'h10, '0);
    chk(log0.size() == 0, "R3 hit without bus", 32'(log0.size()), 32'd0);

    // R4 / R2: write on Exclusive fill is local
    op(0, 1, 8'h10, 16'hAAAA);
    chk(log0.size() == 0, "R4 local write on exclusive line", 32'(log0.size()), 32'd0);
    op(0, 0, 8'h10, '0);

    // R7: peer read of dirty line is served by the owner, memory captures
    s0 = sup_cnt[0];
    op(1, 0, 8'h10, '0);
    chk(sup_cnt[0] == s0 + 1, "R7 owner supplies", 32'(sup_cnt[0]), 32'(s0 + 1));
    chk(mem[8'h10] == 16'hAAAA, "R7 memory captures supplied word", 32'(mem[8'h10]), 32'hAAAA);

    // R5: write on Shared issues invalidate
    clear_logs();
    op(0, 1, 8'h10, 16'hBBBB);
    chk(log0.size() == 1 && log0[0][LW-1 -: 2] == 2'd2 && log0[0][DW +: AW] == 8'h10,
        "R5 invalidate before write", 32'(log0.size() > 0 ? log0[0][LW-1 -: 2] : 2'd0), 32'd2);
    // R9: peer copy now Invalid, re-read misses and gets new data
    clear_logs();
    op(1, 0, 8'h10, '0);
    chk(log1.size() == 1, "R9 invalidated peer misses", 32'(log1.size()), 32'd1);

    // R8: peer read of Exclusive line: shared, no supply
    op(0, 0, 8'h05, '0);
    s0 = sup_cnt[0];
    op(1, 0, 8'h05, '0);
    chk(sup_cnt[0] == s0, "R8 exclusive owner does not supply", 32'(sup_cnt[0]), 32'(s0));
    clear_logs();
    op(0, 1, 8'h05, 16'h5A5A);
    chk(log0.size() == 1 && log0[0][LW-1 -: 2] == 2'd2, "R8 exclusive became shared",
        32'(log0.size()), 32'd1);

    // R6: write miss issues read-for-ownership; R9 dirty owner supplies then drops
    clear_logs();
    op(1, 1, 8'h05, 16'h5555);
    chk(log1.size() == 1 && log1[0][LW-1 -: 2] == 2'd1, "R6 write miss issues cmd 1",
        32'(log1.size()), 32'd1);
    chk(mem[8'h05] == 16'h5A5A, "R9 dirty data captured on ownership read", 32'(mem[8'h05]), 32'h5A5A);
    clear_logs();
    op(0, 0, 8'h05, '0);
    chk(log0.size() == 1, "R9 former owner misses", 32'(log0.size()), 32'd1);

    // R2: Shared fill must upgrade before writing
    op(0, 0, 8'h06, '0);
    op(1, 0, 8'h06, '0);
    clear_logs();
    op(1, 1, 8'h06, 16'h6666);
    chk(log1.size() == 1 && log1[0][LW-1 -: 2] == 2'd2, "R2 shared fill issues invalidate",
        32'(log1.size()), 32'd1);

    // R10: dirty victim is written back before the new fill
    op(0, 1, 8'h03, 16'h3333);
    clear_logs();
    op(0, 0, 8'h07, '0);
    chk(log0.size() == 2, "R10 two transactions", 32'(log0.size()), 32'd2);
    if (log0.size() == 2) begin
      chk(log0[0] == {2'd3, 8'h03, 16'h3333}, "R10 writeback first", 32'(log0[0]),
          32'({2'd3, 8'h03, 16'h3333}));
      chk(log0[1][LW-1 -: 2] == 2'd0 && log0[1][DW +: AW] == 8'h07, "R10 fill second",
          32'(log0[1][DW +: AW]), 32'h07);
    end
    chk(mem[8'h03] == 16'h3333, "R10 memory holds victim", 32'(mem[8'h03]), 32'h3333);

    // R11: processor hit request waits while a peer transaction is snooped
    fork
      op(1, 0, 8'h2B, '0);
      begin
        @(posedge clk);
        #2 op(0, 0, 8'h07, '0);
      end
    join
    chk(stall_seen > 0, "R11 snoop cycle overlapped request", 32'(stall_seen), 32'd1);

    // R12: upgrade race on 0x10, peer wins the bus
    prefer_b = 1'b1;
    clear_logs();
    fork
      op(0, 1, 8'h10, 16'hA1A1);
      op(1, 1, 8'h10, 16'hB2B2);
    join
    gold[8'h10] = 16'hA1A1;
    prefer_b = 1'b0;
    chk(log1.size() >= 1 && log1[0][LW-1 -: 2] == 2'd2, "R12 winner invalidates",
        32'(log1.size()), 32'd1);
    chk(log0.size() == 1 && log0[0][LW-1 -: 2] == 2'd1, "R12 loser refetches with cmd 1",
        32'(log0.size()), 32'd1);
    chk(mem[8'h10] == 16'hB2B2, "R12 winner data reached memory", 32'(mem[8'h10]), 32'hB2B2);
    op(1, 0, 8'h10, '0);

    @(negedge clk);
    chk(expq0.size() == 0 && expq1.size() == 0, "R3 all reads completed",
        32'(expq0.size() + expq1.size()), 32'd0);
    finish_run();
  end
endmodule